// File: doc/BRIEF.md
# Six-State Custom-Order Counter with Asynchronous Force Controls

This block is a 3-bit synchronous counter. On each rising clock edge it steps through a fixed six-state loop that is not in binary order. Each state bit sits in its own D flip-flop. A small piece of next-state logic computes one D input equation per bit from the present state.

Two kinds of asynchronous control let an operator load any of the eight codes without a clock edge. One active-low clear line is shared by all three flip-flops. Each flip-flop also has its own active-low preset line. Together these can also load the two codes that lie outside the loop. When one of those codes is left in the register, the next clock edge sends the counter back to the loop, so the counter starts itself correctly.

The states, written with bit 2 as the leftmost digit, are named as follows:
- Loop states: `ST_P0`=000, `ST_P1`=100, `ST_P2`=001, `ST_P3`=110, `ST_P4`=101, `ST_P5`=111.
- Off-loop states: `ST_X2`=010 and `ST_X3`=011.

The transitions are:
- P0→P1, P1→P2, P2→P3, P3→P4, P4→P5 and P5→P0.
- X2→P0 and X3→P0.

Top module: `seqc_counter`

## Requirements
- R1: With every control inactive (high), each rising clock edge moves the state along 000→100→001→110→101→111→000, where bit 2 is the leftmost digit.
- R2: Driving `clr_n` low forces the state to 000 at once, without waiting for a clock edge.
- R3: Driving `pre_n[i]` low while `clr_n` is high forces state bit i to 1 at once. The other bits keep their values.
- R4: When `clr_n` and any `pre_n` bit are low together, the state is 000 (clear wins).
- R5: From either off-loop code, 010 or 011, the next clock edge with all controls inactive gives 000.
- R6: While `clr_n` stays low, clock edges leave the state at 000.
- R7: While `pre_n[i]` stays low, bit i stays 1 across clock edges. The other bits take their next-state values on each edge.
- R8: After all controls return high, counting resumes from the forced state on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| clr_n | input | 1 | Shared asynchronous clear, active low; forces 000 |
| pre_n | input | 3 | Per-bit asynchronous preset, active low; bit i sets state bit i |
| state | output | 3 | Present counter state, bit 2 leftmost |

## Verification
The bench forces both off-loop codes and checks that the next edge gives 000. A design with a wrong D equation for an unused code would lock up or join the loop at the wrong point. It lowers clear and preset together: a design where preset takes priority would show a 1 where 000 is expected. It checks the state between edges just after each control falls, which catches a design that waits for a clock before clearing or setting. It also holds one preset low across several edges. This exposes a design whose preset blocks the other bits from updating, and a design that lets the held bit fall back to 0.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
    localparam int SEQ_W = 3;

    typedef enum logic [SEQ_W-1:0] {
        ST_P0 = 3'b000,
        ST_P1 = 3'b100,
        ST_P2 = 3'b001,
        ST_P3 = 3'b110,
        ST_P4 = 3'b101,
        ST_P5 = 3'b111,
        ST_X2 = 3'b010,
        ST_X3 = 3'b011
    } seqc_state_e;
endpackage

// File: rtl/seqc_next.sv
module seqc_next
    import seqc_pkg::*;
(
    input  logic [SEQ_W-1:0] cur,
    output logic [SEQ_W-1:0] nxt
);
    seqc_state_e cur_s;
    seqc_state_e nxt_s;

    assign cur_s = seqc_state_e'(cur);

    always_comb begin
        unique case (cur_s)
            ST_P0:   nxt_s = ST_P1;
            ST_P1:   nxt_s = ST_P2;
            ST_P2:   nxt_s = ST_P3;
            ST_P3:   nxt_s = ST_P4;
            ST_P4:   nxt_s = ST_P5;
            ST_P5:   nxt_s = ST_P0;
            ST_X2:   nxt_s = ST_P0;
            ST_X3:   nxt_s = ST_P0;
            default: nxt_s = ST_P0;
        endcase
    end

    assign nxt = nxt_s;
endmodule

// File: rtl/seqc_cell.sv
module seqc_cell (
    input  logic clk,
    input  logic clr_n,
    input  logic pre_n,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge clr_n or negedge pre_n) begin
        if (!clr_n)
            q <= 1'b0;
        else if (!pre_n)
            q <= 1'b1;
        else
            q <= d;
    end
endmodule

// File: rtl/seqc_bank.sv
module seqc_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] pre_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_cell
        seqc_cell u_cell (
            .clk   (clk),
            .clr_n (clr_n),
            .pre_n (pre_n[i]),
            .d     (d[i]),
            .q     (q[i])
        );
    end
endmodule

// File: rtl/seqc_counter.sv
module seqc_counter
    import seqc_pkg::*;
(
    input  logic             clk,
    input  logic             clr_n,
    input  logic [SEQ_W-1:0] pre_n,
    output logic [SEQ_W-1:0] state
);
    logic [SEQ_W-1:0] cur_q;
    logic [SEQ_W-1:0] nxt_d;

    seqc_next u_next (
        .cur (cur_q),
        .nxt (nxt_d)
    );

    seqc_bank #(.W(SEQ_W)) u_bank (
        .clk   (clk),
        .clr_n (clr_n),
        .pre_n (pre_n),
        .d     (nxt_d),
        .q     (cur_q)
    );

    always_comb begin
        state = cur_q;
    end
endmodule

// File: rtl/seqc_counter_chk.sv
module seqc_counter_chk (
    input logic       clk,
    input logic       clr_n,
    input logic [2:0] pre_n,
    input logic [2:0] state
);
    function automatic logic [2:0] succ(input logic [2:0] s);
        case (s)
            3'b000:  succ = 3'b100;
            3'b100:  succ = 3'b001;
            3'b001:  succ = 3'b110;
            3'b110:  succ = 3'b101;
            3'b101:  succ = 3'b111;
            default: succ = 3'b000;
        endcase
    endfunction

    AST_CLEAR_ZERO: assert property (@(negedge clk)
        !clr_n |-> state == 3'b000); // R2

    AST_PRESET_ONE: assert property (@(negedge clk) disable iff (!clr_n)
        ((~pre_n) & (~state)) == 3'b000); // R3

    AST_CLEAR_WINS: assert property (@(negedge clk)
        (!clr_n && pre_n != 3'b111) |-> state == 3'b000); // R4

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        (&pre_n && state[2:1] != 2'b01) |=> (!(&pre_n) || state == succ($past(state)))); // R1

    AST_UNUSED_EXIT: assert property (@(posedge clk) disable iff (!clr_n)
        (&pre_n && state[2:1] == 2'b01) |=> (!(&pre_n) || state == 3'b000)); // R5
endmodule

bind seqc_counter seqc_counter_chk u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .pre_n (pre_n),
    .state (state)
);

// File: tb/tb_seqc_counter.sv
`timescale 1ns/1ps
module tb_seqc_counter;
    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic [2:0] pre_n = 3'b111;
    logic [2:0] state;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    seqc_counter dut (
        .clk   (clk),
        .clr_n (clr_n),
        .pre_n (pre_n),
        .state (state)
    );

    always #4 clk = ~clk;

    function automatic logic [2:0] exp_next(input logic [2:0] s);
        case (s)
            3'b000:  exp_next = 3'b100;
            3'b100:  exp_next = 3'b001;
            3'b001:  exp_next = 3'b110;
            3'b110:  exp_next = 3'b101;
            3'b101:  exp_next = 3'b111;
            3'b111:  exp_next = 3'b000;
            default: exp_next = 3'b000;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        n_checks++;
        if (state !== exp) begin
            n_fail++;
            $display("FAIL %s: state=%b expected=%b", req, state, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Clear phase spans one edge, then presets load v between edges.
    task automatic force_state(input logic [2:0] v);
        @(negedge clk);
        clr_n = 1'b0;
        step();
        clr_n = 1'b1;
        #1 pre_n = ~v;
        #1 pre_n = 3'b111;
        #0.5;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1 clr_n = 1'b0;
        #0.5 check("R2 reset", 3'b000);
        step();
        check("R6 clear held edge 1", 3'b000);
        step();
        check("R6 clear held edge 2", 3'b000);
        clr_n = 1'b1;
    endtask

    task automatic t_cycle();
        logic [2:0] e;
        force_state(3'b000);
        e = 3'b000;
        for (int k = 0; k < 13; k++) begin
            step();
            e = exp_next(e);
            check("R1 cycle", e);
        end
    endtask

    task automatic t_async_clear();
        force_state(3'b110);
        check("R3 preset load 110", 3'b110);
        #1 clr_n = 1'b0;
        #0.5 check("R2 async clear mid-cycle", 3'b000);
        step();
        check("R6 clear held", 3'b000);
        clr_n = 1'b1;
    endtask

    task automatic t_presets();
        @(negedge clk);
        clr_n = 1'b0;
        step();
        clr_n = 1'b1;
        #1 pre_n = 3'b011;
        #0.5 check("R3 preset bit2", 3'b100);
        pre_n = 3'b111;
        #0.5 pre_n = 3'b110;
        #0.5 check("R3 preset bit0 keeps bit2", 3'b101);
        pre_n = 3'b111;
        #0.5 pre_n = 3'b101;
        #0.5 check("R3 preset bit1 keeps others", 3'b111);
        pre_n = 3'b111;
        step();
        check("R8 resume from 111", 3'b000);
    endtask

    task automatic t_clear_wins();
        @(negedge clk);
        clr_n = 1'b0;
        #1 pre_n = 3'b000;
        #0.5 check("R4 clear beats all presets", 3'b000);
        pre_n = 3'b111;
        step();
        check("R4 clear held after preset drop", 3'b000);
        clr_n = 1'b1;
    endtask

    task automatic t_unused();
        force_state(3'b010);
        check("R5 forced 010", 3'b010);
        step();
        check("R5 exit from 010", 3'b000);
        force_state(3'b011);
        check("R5 forced 011", 3'b011);
        step();
        check("R5 exit from 011", 3'b000);
        step();
        check("R5 loop rejoined", 3'b100);
    endtask

    task automatic t_preset_hold();
        @(negedge clk);
        clr_n = 1'b0;
        step();
        clr_n = 1'b1;
        #1 pre_n = 3'b110;
        #0.5 check("R7 hold bit0 start", 3'b001);
        step();
        check("R7 hold bit0 edge 1", 3'b111);
        step();
        check("R7 hold bit0 edge 2", 3'b001);
        step();
        check("R7 hold bit0 edge 3", 3'b111);
        pre_n = 3'b111;
        step();
        check("R8 resume after hold", 3'b000);
    endtask

    task automatic t_resume();
        force_state(3'b101);
        check("R8 forced 101", 3'b101);
        step();
        check("R8 resume 101->111", 3'b111);
        step();
        check("R8 resume 111->000", 3'b000);
    endtask

    initial begin
        t_reset();
        t_cycle();
        t_async_clear();
        t_presets();
        t_clear_wins();
        t_unused();
        t_preset_hold();
        t_resume();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: state=%b expected=done", state);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule